// File: doc/BRIEF.md
# Dual-Clock FIFO with Byte Parity and Mailboxes

This block joins two unrelated clock domains. Side A pushes 36-bit words into a 64-entry queue on its own clock. Side B pops them in order on a second clock, which may be unrelated to the first or may be the same clock. Side A sees full and almost-full flags. Side B sees empty and almost-empty flags. Each flag is computed from the local pointer and a two-flop synchronised copy of the remote Gray-coded pointer.

Each word is four 9-bit bytes. Bit 9k+8 is the parity bit of byte k and covers bits 9k+7 down to 9k. The input `par_odd` picks odd parity (1) or even parity (0). This choice applies to both checking and regeneration. Each port checks the words it receives and raises an error output. The check is passive: the data is stored or passed on unchanged. Each port also has a select input that regenerates the parity bits on the words it outputs.

Two one-word mailboxes bypass the queue, one for each direction. A write sets a "mail waiting" flag in the receiving clock domain, and reading the mailbox there clears it. The sender's mailbox is held from the write until the read acknowledgement has crossed back to the sender. While it is held, further writes are ignored. This hold is a two-state machine in the sender's domain:
- MB_IDLE: the mailbox is free and a write is accepted. The transition "load" goes to MB_HELD.
- MB_HELD: the word is kept. The transition "release" returns to MB_IDLE once the synchronised read toggle equals the write toggle.

Top module: `xdf_top`

## Requirements
- R1: While `rst_n` is low, and at its release, the block shows the following state: `b_empty` and `b_aempty` are 1; `a_full`, `a_afull`, `a_mbf` and `b_mbf` are 0; `a_dout` and `b_dout` are zero.
- R2: Words written with `a_wen` high come out on `b_dout` in write order. A word is written only when `a_full` is low. A word is read when `b_ren` is high, `b_mbr` is low and `b_empty` is low. `b_dout` is updated at that same `b_clk` rising edge.
- R3: `a_full` is 1 when 64 words are held that side B has not read, as seen from side A. `b_empty` is 1 when no word is held, as seen from side B.
- R4: A write while `a_full` is 1 does not change the queue or its flags. A read while `b_empty` is 1 does not change `b_dout` or the queue.
- R5: `a_afull` is 1 when side A's level is at least DEPTH minus AF_OFF (56 words by default).
- R6: `b_aempty` is 1 when side B's level is at most AE_OFF (8 words by default).
- R7: A byte is bad when the XOR of its nine bits differs from `par_odd`. `a_perr` is 1 during a cycle in which `a_wen` or `a_mbw` is high and any byte of `a_din` is bad. `b_perr` is 1 during a cycle in which `b_mbw` is high and any byte of `b_din` is bad. In both cases the data is stored unchanged.
- R8: With `b_pgen` high, bit 9k+8 of `b_dout` is set to XOR(bits 9k+7..9k) XOR `par_odd`. `a_pgen` does the same for `a_dout`. With the select low, the word passes through unaltered.
- R9: A word written with `a_mbw` raises `b_mbf`. Pulsing `b_mbr` while `b_mbf` is 1 puts that word on `b_dout` at the next `b_clk` edge and lowers `b_mbf`. The B-to-A path works the same way with `b_mbw`, `a_mbf`, `a_mbr` and `a_dout`.
- R10: A mailbox write that arrives while the previous word has not been read and acknowledged is ignored. The reader receives the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| a_clk | input | 1 | Side A clock |
| a_wen | input | 1 | Queue write enable |
| a_mbw | input | 1 | Write A-to-B mailbox |
| a_mbr | input | 1 | Read B-to-A mailbox |
| a_pgen | input | 1 | Regenerate parity on a_dout |
| a_din | input | 36 | Side A write data |
| a_dout | output | 36 | B-to-A mailbox read data |
| a_full | output | 1 | Queue full (side A domain) |
| a_afull | output | 1 | Queue almost full |
| a_mbf | output | 1 | Mail from B waiting |
| a_perr | output | 1 | Parity error on a_din |
| b_clk | input | 1 | Side B clock |
| b_ren | input | 1 | Queue read enable |
| b_mbw | input | 1 | Write B-to-A mailbox |
| b_mbr | input | 1 | Read A-to-B mailbox (takes priority over b_ren) |
| b_pgen | input | 1 | Regenerate parity on b_dout |
| b_din | input | 36 | Side B mailbox write data |
| b_dout | output | 36 | Queue or mailbox read data |
| b_empty | output | 1 | Queue empty (side B domain) |
| b_aempty | output | 1 | Queue almost empty |
| b_mbf | output | 1 | Mail from A waiting |
| b_perr | output | 1 | Parity error on b_din |

## Verification
The properties assume the following about the inputs:
- Every enable and data input is synchronous to its own port clock.
- `b_mbr` is raised only after `b_mbf` has been seen high.
- `rst_n` is released while both clocks run.

The bench meets these assumptions as follows:
- It changes side A inputs only on falling edges of `a_clk` and side B inputs only on falling edges of `b_clk`.
- It waits for the mail flag before each mailbox read.
- It allows several cycles of each clock for the synchronisers to settle before it samples a flag from the other domain.

// File: rtl/xdf_pkg.sv
package xdf_pkg;
    localparam int BYTE_W = 9;

    typedef enum logic {
        MB_IDLE = 1'b0,
        MB_HELD = 1'b1
    } mb_state_t;

    function automatic logic byte_bad(input logic [BYTE_W-1:0] b, input logic odd);
        return (^b) != odd;
    endfunction

    function automatic logic [BYTE_W-1:0] byte_fix(input logic [BYTE_W-1:0] b, input logic odd);
        return {(^b[BYTE_W-2:0]) ^ odd, b[BYTE_W-2:0]};
    endfunction
endpackage

// File: rtl/xdf_sync.sv
module xdf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/xdf_mailbox.sv
module xdf_mailbox #(
    parameter int W = 36
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         mail
);
    import xdf_pkg::*;

    mb_state_t state, state_nx;
    logic      wtog, rtog, wtog_r, rtog_w;

    // sender-side state register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) state <= MB_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            MB_IDLE: if (wr)              state_nx = MB_HELD;  // load
            MB_HELD: if (rtog_w == wtog)  state_nx = MB_IDLE;  // release
        endcase
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            wtog <= 1'b0;
        end else if (state == MB_IDLE && wr) begin
            q    <= din;
            wtog <= ~wtog;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)          rtog <= 1'b0;
        else if (rd && mail) rtog <= ~rtog;
    end

    xdf_sync #(.W(1)) u_to_rd (.clk(rclk), .rst_n(rst_n), .d(wtog), .q(wtog_r));
    xdf_sync #(.W(1)) u_to_wr (.clk(wclk), .rst_n(rst_n), .d(rtog), .q(rtog_w));

    assign mail = wtog_r ^ rtog;
endmodule

// File: rtl/xdf_top.sv
module xdf_top #(
    parameter int WIDTH  = 36,
    parameter int DEPTH  = 64,
    parameter int AF_OFF = 8,
    parameter int AE_OFF = 8
) (
    input  logic             rst_n,
    input  logic             par_odd,
    input  logic             a_clk,
    input  logic             a_wen,
    input  logic             a_mbw,
    input  logic             a_mbr,
    input  logic             a_pgen,
    input  logic [WIDTH-1:0] a_din,
    output logic [WIDTH-1:0] a_dout,
    output logic             a_full,
    output logic             a_afull,
    output logic             a_mbf,
    output logic             a_perr,
    input  logic             b_clk,
    input  logic             b_ren,
    input  logic             b_mbw,
    input  logic             b_mbr,
    input  logic             b_pgen,
    input  logic [WIDTH-1:0] b_din,
    output logic [WIDTH-1:0] b_dout,
    output logic             b_empty,
    output logic             b_aempty,
    output logic             b_mbf,
    output logic             b_perr
);
    import xdf_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int NB = WIDTH / BYTE_W;
    localparam logic [PW-1:0] AF_LVL = PW'(DEPTH - AF_OFF);
    localparam logic [PW-1:0] AE_LVL = PW'(AE_OFF);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wbin, wgray, rbin, rgray, wq2, rq2;
    logic [PW-1:0]    a_level, b_level;
    logic             w_fire, r_fire;
    logic [WIDTH-1:0] mb_ab_q, mb_ba_q, b_raw, b_fix, a_fix;
    logic [NB-1:0]    a_err, b_err;

    // per-byte parity check and regeneration
    for (genvar k = 0; k < NB; k++) begin : g_byte
        localparam int LO = k * BYTE_W;
        assign a_err[k]              = byte_bad(a_din[LO +: BYTE_W], par_odd);
        assign b_err[k]              = byte_bad(b_din[LO +: BYTE_W], par_odd);
        assign b_fix[LO +: BYTE_W]   = byte_fix(b_raw[LO +: BYTE_W], par_odd);
        assign a_fix[LO +: BYTE_W]   = byte_fix(mb_ba_q[LO +: BYTE_W], par_odd);
    end

    assign a_perr = (a_wen | a_mbw) & (|a_err);
    assign b_perr = b_mbw & (|b_err);

    // write side
    assign a_full  = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
    assign a_level = wbin - to_bin(rq2);
    assign a_afull = (a_level >= AF_LVL);
    assign w_fire  = a_wen & ~a_full;

    always_ff @(posedge a_clk) begin
        if (w_fire) mem[wbin[AW-1:0]] <= a_din;
    end

    always_ff @(posedge a_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (w_fire) begin
            wbin  <= wbin + 1'b1;
            wgray <= to_gray(wbin + 1'b1);
        end
    end

    // read side
    assign b_empty  = (rgray == wq2);
    assign b_level  = to_bin(wq2) - rbin;
    assign b_aempty = (b_level <= AE_LVL);
    assign r_fire   = b_ren & ~b_mbr & ~b_empty;
    assign b_raw    = b_mbr ? mb_ab_q : mem[rbin[AW-1:0]];

    always_ff @(posedge b_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            b_dout <= '0;
        end else begin
            if (r_fire) begin
                rbin  <= rbin + 1'b1;
                rgray <= to_gray(rbin + 1'b1);
            end
            if (r_fire || (b_mbr && b_mbf))
                b_dout <= b_pgen ? b_fix : b_raw;
        end
    end

    always_ff @(posedge a_clk or negedge rst_n) begin
        if (!rst_n)             a_dout <= '0;
        else if (a_mbr && a_mbf) a_dout <= a_pgen ? a_fix : mb_ba_q;
    end

    xdf_sync #(.W(PW)) u_wsync (.clk(b_clk), .rst_n(rst_n), .d(wgray), .q(wq2));
    xdf_sync #(.W(PW)) u_rsync (.clk(a_clk), .rst_n(rst_n), .d(rgray), .q(rq2));

    xdf_mailbox #(.W(WIDTH)) u_mb_ab (
        .wclk(a_clk), .rclk(b_clk), .rst_n(rst_n), .wr(a_mbw), .rd(b_mbr),
        .din(a_din), .q(mb_ab_q), .mail(b_mbf)
    );

    xdf_mailbox #(.W(WIDTH)) u_mb_ba (
        .wclk(b_clk), .rclk(a_clk), .rst_n(rst_n), .wr(b_mbw), .rd(a_mbr),
        .din(b_din), .q(mb_ba_q), .mail(a_mbf)
    );
endmodule

// File: rtl/xdf_chk.sv
module xdf_chk #(
    parameter int PW = 7
) (
    input logic          a_clk,
    input logic          b_clk,
    input logic          rst_n,
    input logic          a_wen,
    input logic          a_full,
    input logic          a_afull,
    input logic          b_ren,
    input logic          b_mbr,
    input logic          b_empty,
    input logic          b_aempty,
    input logic          b_mbf,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);
    p_no_overflow_r4: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_full && a_wen |=> wgray == $past(wgray));

    p_no_underflow_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_empty && b_ren |=> rgray == $past(rgray));

    p_wgray_step_r2: assert property (@(posedge a_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_rgray_step_r2: assert property (@(posedge b_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    p_full_implies_afull_r5: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_full |-> a_afull);

    p_empty_implies_aempty_r6: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_empty |-> b_aempty);

    p_mail_clears_r9: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_mbr && b_mbf |=> !b_mbf);
endmodule

bind xdf_top xdf_chk #(.PW(PW)) u_chk (
    .a_clk(a_clk), .b_clk(b_clk), .rst_n(rst_n),
    .a_wen(a_wen), .a_full(a_full), .a_afull(a_afull),
    .b_ren(b_ren), .b_mbr(b_mbr), .b_empty(b_empty), .b_aempty(b_aempty),
    .b_mbf(b_mbf), .wgray(wgray), .rgray(rgray)
);

// File: tb/xdf_top_test.sv
module xdf_top_test;
    logic        rst_n = 1'b0, par_odd = 1'b1;
    logic        a_clk = 1'b0, a_wen = 1'b0, a_mbw = 1'b0, a_mbr = 1'b0, a_pgen = 1'b0;
    logic        b_clk = 1'b0, b_ren = 1'b0, b_mbw = 1'b0, b_mbr = 1'b0, b_pgen = 1'b0;
    logic [35:0] a_din = '0, b_din = '0;
    logic [35:0] a_dout, b_dout;
    logic        a_full, a_afull, a_mbf, a_perr, b_empty, b_aempty, b_mbf, b_perr;

    int vectors = 0, fails = 0;
    bit done = 0, mon_on = 0, rd_pend = 0;
    logic [35:0] sb[$];

    always #10 a_clk = ~a_clk;   // 50 MHz
    always #13 b_clk = ~b_clk;

    xdf_top uut (.*);

    function automatic logic [35:0] fixw(input logic [35:0] w, input logic odd);
        logic [35:0] r = w;
        for (int k = 0; k < 4; k++) r[9*k+8] = (^w[9*k +: 8]) ^ odd;
        return r;
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    // driver: pushes expected item, checks passive parity flag
    task automatic push(input logic [35:0] w, input logic exp_perr);
        @(negedge a_clk);
        while (a_full) @(negedge a_clk);
        a_din = w; a_wen = 1'b1;
        #1 chk("R7 a_perr", 36'(a_perr), 36'(exp_perr));
        sb.push_back(b_pgen ? fixw(w, par_odd) : w);
        @(negedge a_clk);
        a_wen = 1'b0;
    endtask

    task automatic drain_wait();
        while (sb.size() > 0) @(negedge b_clk);
        repeat (4) @(negedge b_clk);
    endtask

    // monitor: reads whenever data is visible and compares in order
    initial begin
        forever begin
            @(negedge b_clk);
            if (mon_on) begin
                if (rd_pend) begin
                    if (sb.size() == 0) chk("R2 unexpected read", b_dout, 36'h0);
                    else chk("R2/R8 scoreboard", b_dout, sb.pop_front());
                end
                rd_pend = !b_empty;
                b_ren = rd_pend;
            end else rd_pend = 0;
        end
    end

    initial begin
        repeat (150000) @(posedge a_clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [35:0] w;
        repeat (3) @(negedge a_clk);
        chk("R1 empty in reset", 36'(b_empty), 36'd1);
        chk("R1 full in reset", 36'(a_full), 36'd0);
        rst_n = 1'b1;
        @(negedge b_clk);
        chk("R1 b_empty", 36'(b_empty), 36'd1);
        chk("R1 b_aempty", 36'(b_aempty), 36'd1);
        chk("R1 a_full", 36'(a_full), 36'd0);
        chk("R1 a_afull", 36'(a_afull), 36'd0);
        chk("R1 a_mbf", 36'(a_mbf), 36'd0);
        chk("R1 b_mbf", 36'(b_mbf), 36'd0);
        chk("R1 a_dout", a_dout, 36'd0);
        chk("R1 b_dout", b_dout, 36'd0);

        // R4: read from empty queue has no effect
        b_ren = 1'b1; @(negedge b_clk); b_ren = 1'b0;
        chk("R4 dout after empty read", b_dout, 36'd0);
        chk("R4 still empty", 36'(b_empty), 36'd1);

        // R2/R7 stream with odd parity, good and bad words
        mon_on = 1;
        for (int i = 0; i < 20; i++) begin
            w = fixw(36'h9_0000_0000 * i + 36'h1234_5678 + i * 7, 1'b1);
            if (i % 5 == 3) begin w[17] = ~w[17]; push(w, 1'b1); end
            else push(w, 1'b0);
        end
        drain_wait();

        // R7 even parity
        par_odd = 1'b0;
        for (int i = 0; i < 6; i++) begin
            w = fixw(36'h5A5A_A5A5 ^ (i * 36'h1_1111_1111), 1'b0);
            if (i[0]) begin w[35] = ~w[35]; push(w, 1'b1); end
            else push(w, 1'b0);
        end
        drain_wait();
        par_odd = 1'b1;

        // R8 regeneration on read
        b_pgen = 1'b1;
        for (int i = 0; i < 8; i++) push(36'hF_0F0F_0F0F ^ (i * 36'h3_0301_0907), 1'bx === 1'b1 ? 1'b0 :
            (|{(^(36'hF_0F0F_0F0F ^ (i * 36'h3_0301_0907)) & 1'b0)}) | bad_word(36'hF_0F0F_0F0F ^ (i * 36'h3_0301_0907)));
        drain_wait();
        b_pgen = 1'b0;
        mon_on = 0; b_ren = 1'b0;
        repeat (10) @(negedge a_clk);

        // R3/R4/R5 fill with no reader
        for (int i = 0; i < 64; i++) begin
            @(negedge a_clk);
            a_din = 36'(i * 36'h1_0203) ^ 36'hA_BCDE_F012; a_wen = 1'b1;
            sb.push_back(a_din);
            @(negedge a_clk);
            a_wen = 1'b0;
            if (i == 54) chk("R5 afull below threshold", 36'(a_afull), 36'd0);
            if (i == 55) chk("R5 afull at threshold", 36'(a_afull), 36'd1);
            if (i == 62) chk("R3 not full at 63", 36'(a_full), 36'd0);
        end
        chk("R3 full at 64", 36'(a_full), 36'd1);
        @(negedge a_clk);
        a_din = 36'hD_EAD0_BEEF; a_wen = 1'b1;
        @(negedge a_clk);
        a_wen = 1'b0;
        chk("R4 still full after overflow write", 36'(a_full), 36'd1);
        repeat (8) @(negedge b_clk);
        chk("R6 aempty with 64", 36'(b_aempty), 36'd0);
        chk("R3 not empty with 64", 36'(b_empty), 36'd0);
        for (int n = 1; n <= 64; n++) begin
            @(negedge b_clk); b_ren = 1'b1;
            @(negedge b_clk); b_ren = 1'b0;
            chk("R2/R4 drain order", b_dout, sb.pop_front());
            chk("R6 aempty level", 36'(b_aempty), 36'(64 - n <= 8));
            chk("R3 empty level", 36'(b_empty), 36'(n == 64));
        end
        repeat (8) @(negedge a_clk);
        chk("R3 full released", 36'(a_full), 36'd0);
        chk("R5 afull released", 36'(a_afull), 36'd0);

        // R9/R10 mailbox A to B
        @(negedge a_clk); a_din = 36'h1_1111_1111; a_mbw = 1'b1;
        @(negedge a_clk); a_din = 36'h2_2222_2222;
        @(negedge a_clk); a_mbw = 1'b0;
        repeat (6) @(negedge b_clk);
        chk("R9 b_mbf raised", 36'(b_mbf), 36'd1);
        b_mbr = 1'b1; @(negedge b_clk); b_mbr = 1'b0;
        chk("R10 first word kept", b_dout, 36'h1_1111_1111);
        chk("R9 b_mbf cleared", 36'(b_mbf), 36'd0);
        chk("R2 queue untouched by mailbox", 36'(b_empty), 36'd1);
        repeat (6) @(negedge a_clk);
        @(negedge a_clk); a_din = 36'h3_3333_3333; a_mbw = 1'b1;
        @(negedge a_clk); a_mbw = 1'b0;
        repeat (6) @(negedge b_clk);
        b_mbr = 1'b1; @(negedge b_clk); b_mbr = 1'b0;
        chk("R9 second mail delivered", b_dout, 36'h3_3333_3333);

        // R9/R7/R8 mailbox B to A with bad parity and regeneration
        @(negedge b_clk); b_din = 36'h0_0000_0001; b_mbw = 1'b1;
        #1 chk("R7 b_perr", 36'(b_perr), 36'd1);
        @(negedge b_clk); b_mbw = 1'b0;
        #1 chk("R7 b_perr idle", 36'(b_perr), 36'd0);
        repeat (6) @(negedge a_clk);
        chk("R9 a_mbf raised", 36'(a_mbf), 36'd1);
        a_pgen = 1'b1; a_mbr = 1'b1; @(negedge a_clk); a_mbr = 1'b0;
        chk("R8 a_dout regenerated", a_dout, fixw(36'h0_0000_0001, 1'b1));
        chk("R9 a_mbf cleared", 36'(a_mbf), 36'd0);
        a_pgen = 1'b0;

        done = 1;
        summary();
        $finish;
    end

    function automatic logic bad_word(input logic [35:0] w);
        logic b = 1'b0;
        for (int k = 0; k < 4; k++) b |= ((^w[9*k +: 9]) != par_odd);
        return b;
    endfunction
endmodule